// File: doc/BRIEF.md
# Audio Clock Speed-Mode Detector

This block watches the clocks of a serial audio input and works out how they are set up. In the MCLK domain it counts master-clock cycles between successive rising edges of the frame clock (LRCK). In a free-running reference-clock domain it measures the LRCK period, which gives the sample rate. The count is handed to the reference domain by a toggle event, and the value travels with it in a register that holds still for a whole frame. Everything after that point runs on the reference clock.

The sample rate is resolved into a speed band first. The MCLK-to-LRCK ratio is then matched only against the ratios allowed in that band. This matters because several ratios, 256x for example, are legal in more than one band. A result that repeats for several frames in a row raises a locked flag. A ratio that is not allowed, a rate outside the supported range, or a frame clock that has stopped raises an unsupported flag instead.

Top module: `clkmode_detect`

## Requirements
- R1: While reset is asserted and right after it is released, `mode_o`, `ratio_o`, `locked_o` and `unsupported_o` are all 0.
- R2: `mode_o` encodes the band of the measured LRCK rate. 1 = single (at most SGL_MAX_HZ, 50 kHz), 2 = double (at most DBL_MAX_HZ, 100 kHz), 3 = quad (above that). 0 = no band, when the rate is below MIN_FS_HZ (30 kHz) or above MAX_FS_HZ (220 kHz).
- R3: `ratio_o` encodes a recognised ratio. 1=64x, 2=96x, 3=128x, 4=192x, 5=256x, 6=384x, 7=512x, 8=768x, 9=1024x, 10=1152x.
- R4: A ratio is accepted only from its band's own set. Single: 256x to 1152x. Double: 128x, 192x, 256x, 384x, 512x. Quad: 64x, 96x, 128x, 192x, 256x. For example, 512x at 192 kHz is unsupported.
- R5: A measured MCLK count within ±TOL (2) of a nominal ratio is accepted as that ratio. An offset of 3 or more is unsupported.
- R6: Ratios left out of a band's auto-detect mask are reported as unsupported. By default, 1152x in single speed is left out.
- R7: When unsupported, `unsupported_o`=1, `ratio_o`=0 and `locked_o`=0, and `mode_o` still shows the band. While locked, `unsupported_o`=0, `mode_o`≠0 and `ratio_o`≠0.
- R8: `locked_o` rises only after LOCK_RUNS (4) consecutive LRCK periods have given the same band and ratio.
- R9: `locked_o` falls on the first period whose band or ratio differs, or whose ratio is unsupported.
- R10: If no LRCK rising edge arrives for more than REF_HZ/MIN_FS_HZ reference cycles, `mode_o`=0, `ratio_o`=0, `unsupported_o`=1 and `locked_o`=0. Detection resumes once edges return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock, REF_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Audio master clock |
| lrck | input | 1 | Audio frame clock |
| mode_o | output | 2 | Speed band code (R2) |
| ratio_o | output | 4 | MCLK/LRCK ratio code (R3) |
| locked_o | output | 1 | Stable result for LOCK_RUNS periods |
| unsupported_o | output | 1 | Clocking not recognised or LRCK stopped |

## Verification
The detector is driven with clocking that covers every band, and with the same 256x ratio at 48, 96 and 192 kHz. This shows that the band is resolved before the ratio is matched. A ratio that is legal elsewhere but not in the current band (512x at quad speed), the masked 1152x, and offsets of ±2 and +3 MCLK cycles separate accepted ratios from unsupported ones. A 20 kHz rate and a stopped LRCK exercise the no-band path. Switching between results shows when lock drops and how many frames pass before it returns.

// File: rtl/clkmode_pkg.sv
`timescale 1ps/1ps
package clkmode_pkg;

  typedef enum logic [1:0] {
    BAND_NONE   = 2'd0,
    BAND_SINGLE = 2'd1,
    BAND_DOUBLE = 2'd2,
    BAND_QUAD   = 2'd3
  } band_e;

  localparam int unsigned NUM_RATIOS = 10;
  localparam int unsigned RCODE_W    = 4;

  // nominal MCLK cycles per frame for ratio code 1..NUM_RATIOS
  function automatic int unsigned ratio_of(int unsigned code);
    case (code)
      1:       return 64;
      2:       return 96;
      3:       return 128;
      4:       return 192;
      5:       return 256;
      6:       return 384;
      7:       return 512;
      8:       return 768;
      9:       return 1024;
      10:      return 1152;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/cmd_sync.sv
`timescale 1ps/1ps
module cmd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cmd_mclk_count.sv
`timescale 1ps/1ps
module cmd_mclk_count #(
  parameter int unsigned MCNT_W = 12
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              lrck_s,
  output logic [MCNT_W-1:0] hold_o,
  output logic              tog_o
);
  logic              lrck_q;
  logic              armed_q, armed_d;
  logic [MCNT_W-1:0] cnt_q, cnt_d;
  logic [MCNT_W-1:0] hold_q, hold_d;
  logic              tog_q, tog_d;
  logic              rise;

  assign rise = lrck_s & ~lrck_q;

  always_comb begin
    cnt_d   = cnt_q;
    hold_d  = hold_q;
    tog_d   = tog_q;
    armed_d = armed_q;
    if (rise) begin
      cnt_d   = MCNT_W'(1);
      armed_d = 1'b1;
      if (armed_q) begin
        hold_d = cnt_q;
        tog_d  = ~tog_q;
      end
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + MCNT_W'(1);
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      hold_q  <= '0;
      tog_q   <= 1'b0;
    end else begin
      lrck_q  <= lrck_s;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
      tog_q   <= tog_d;
    end
  end

  assign hold_o = hold_q;
  assign tog_o  = tog_q;

  // R3: the handed-off count only moves together with its event toggle
  a_r3_hold_with_toggle: assert property (@(posedge mclk) disable iff (!rst_n)
    !(rise && armed_q) |=> $stable(hold_q) && $stable(tog_q));
endmodule

// File: rtl/cmd_rate_meter.sv
`timescale 1ps/1ps
module cmd_rate_meter #(
  parameter int unsigned PER_W   = 13,
  parameter int unsigned PER_LIM = 4167
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrck_s,
  output logic [PER_W-1:0] period_o,
  output logic             stall_o
);
  logic             lrck_q;
  logic             armed_q, armed_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             rise;

  assign rise = lrck_s & ~lrck_q;

  always_comb begin
    cnt_d   = cnt_q;
    per_d   = per_q;
    armed_d = armed_q;
    if (rise) begin
      cnt_d   = PER_W'(1);
      armed_d = 1'b1;
      if (armed_q) per_d = cnt_q;
    end else if (cnt_q != PER_W'(PER_LIM)) begin
      cnt_d = cnt_q + PER_W'(1);
    end else begin
      per_d = PER_W'(PER_LIM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      per_q   <= PER_W'(PER_LIM);
    end else begin
      lrck_q  <= lrck_s;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      per_q   <= per_d;
    end
  end

  assign period_o = per_q;
  assign stall_o  = (cnt_q == PER_W'(PER_LIM));

  // R10: a fresh frame edge always ends a stall
  a_r10_edge_clears_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !stall_o);
endmodule

// File: rtl/cmd_classify.sv
`timescale 1ps/1ps
module cmd_classify
  import clkmode_pkg::*;
#(
  parameter int unsigned           PER_W       = 13,
  parameter int unsigned           MCNT_W      = 12,
  parameter int unsigned           PER_MIN     = 568,
  parameter int unsigned           PER_MAX     = 4166,
  parameter int unsigned           SGL_MIN_PER = 2500,
  parameter int unsigned           DBL_MIN_PER = 1250,
  parameter int unsigned           TOL         = 2,
  parameter logic [NUM_RATIOS-1:0] SGL_AUTO    = 10'b01_1111_0000,
  parameter logic [NUM_RATIOS-1:0] DBL_AUTO    = 10'b00_0111_1100,
  parameter logic [NUM_RATIOS-1:0] QUAD_AUTO   = 10'b00_0001_1111
) (
  input  logic [PER_W-1:0]   period_i,
  input  logic [MCNT_W-1:0]  mcount_i,
  output band_e              band_o,
  output logic [RCODE_W-1:0] code_o,
  output logic               ok_o
);
  band_e                 band;
  logic [NUM_RATIOS-1:0] near, allow, hit;
  logic [RCODE_W-1:0]    code;

  always_comb begin
    if (period_i > PER_W'(PER_MAX) || period_i < PER_W'(PER_MIN)) band = BAND_NONE;
    else if (period_i >= PER_W'(SGL_MIN_PER))                      band = BAND_SINGLE;
    else if (period_i >= PER_W'(DBL_MIN_PER))                      band = BAND_DOUBLE;
    else                                                           band = BAND_QUAD;
  end

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_ratio
    localparam int unsigned NOM = ratio_of(g + 1);
    localparam int unsigned LO  = NOM - TOL;
    localparam int unsigned HI  = NOM + TOL;
    assign near[g] = (mcount_i >= MCNT_W'(LO)) && (mcount_i <= MCNT_W'(HI));
  end

  always_comb begin
    case (band)
      BAND_SINGLE: allow = SGL_AUTO;
      BAND_DOUBLE: allow = DBL_AUTO;
      BAND_QUAD:   allow = QUAD_AUTO;
      default:     allow = '0;
    endcase
  end

  assign hit = near & allow;

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) code = RCODE_W'(i + 1);
    end
  end

  assign band_o = band;
  assign code_o = code;
  assign ok_o   = |hit;
endmodule

// File: rtl/cmd_lock_track.sv
`timescale 1ps/1ps
module cmd_lock_track
  import clkmode_pkg::*;
#(
  parameter int unsigned LOCK_RUNS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_i,
  input  logic               stall_i,
  input  band_e              band_i,
  input  logic [RCODE_W-1:0] code_i,
  input  logic               ok_i,
  output logic [1:0]         mode_o,
  output logic [RCODE_W-1:0] ratio_o,
  output logic               locked_o,
  output logic               unsup_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUNS + 1);

  band_e              mode_q, mode_d;
  logic [RCODE_W-1:0] code_q, code_d;
  logic               unsup_q, unsup_d;
  logic               lock_q, lock_d;
  logic [RUN_W-1:0]   run_q, run_d;

  always_comb begin
    mode_d  = mode_q;
    code_d  = code_q;
    unsup_d = unsup_q;
    run_d   = run_q;
    if (stall_i) begin
      mode_d  = BAND_NONE;
      code_d  = '0;
      unsup_d = 1'b1;
      run_d   = '0;
    end else if (evt_i) begin
      mode_d = band_i;
      if (ok_i) begin
        code_d  = code_i;
        unsup_d = 1'b0;
        if (run_q != '0 && band_i == mode_q && code_i == code_q)
          run_d = (run_q == RUN_W'(LOCK_RUNS)) ? run_q : run_q + RUN_W'(1);
        else
          run_d = RUN_W'(1);
      end else begin
        code_d  = '0;
        unsup_d = 1'b1;
        run_d   = '0;
      end
    end
    lock_d = (run_d == RUN_W'(LOCK_RUNS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= BAND_NONE;
      code_q  <= '0;
      unsup_q <= 1'b0;
      lock_q  <= 1'b0;
      run_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      code_q  <= code_d;
      unsup_q <= unsup_d;
      lock_q  <= lock_d;
      run_q   <= run_d;
    end
  end

  assign mode_o   = mode_q;
  assign ratio_o  = code_q;
  assign locked_o = lock_q;
  assign unsup_o  = unsup_q;

  // R7: a locked result is always a recognised one
  a_r7_lock_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !unsup_q && mode_q != BAND_NONE && code_q != '0);

  // R9: a differing or rejected frame drops lock at once
  a_r9_drop_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !stall_i && (!ok_i || band_i != mode_q || code_i != code_q)) |=> !lock_q);

  // R8: lock only ever rises on a frame result
  a_r8_rise_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(evt_i));

  // R10: a stall forces the no-band, unsupported state
  a_r10_stall_state: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> unsup_q && !lock_q && mode_q == BAND_NONE && code_q == '0);
endmodule

// File: rtl/clkmode_detect.sv
`timescale 1ps/1ps
module clkmode_detect
  import clkmode_pkg::*;
#(
  parameter int unsigned           REF_HZ      = 125_000_000,
  parameter int unsigned           MIN_FS_HZ   = 30_000,
  parameter int unsigned           MAX_FS_HZ   = 220_000,
  parameter int unsigned           SGL_MAX_HZ  = 50_000,
  parameter int unsigned           DBL_MAX_HZ  = 100_000,
  parameter int unsigned           MCNT_W      = 12,
  parameter int unsigned           TOL         = 2,
  parameter int unsigned           LOCK_RUNS   = 4,
  parameter int unsigned           SYNC_STAGES = 2,
  parameter logic [NUM_RATIOS-1:0] SGL_AUTO    = 10'b01_1111_0000,
  parameter logic [NUM_RATIOS-1:0] DBL_AUTO    = 10'b00_0111_1100,
  parameter logic [NUM_RATIOS-1:0] QUAD_AUTO   = 10'b00_0001_1111
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               mclk,
  input  logic               lrck,
  output logic [1:0]         mode_o,
  output logic [RCODE_W-1:0] ratio_o,
  output logic               locked_o,
  output logic               unsupported_o
);
  localparam int unsigned PER_MAX     = REF_HZ / MIN_FS_HZ;
  localparam int unsigned PER_MIN     = REF_HZ / MAX_FS_HZ;
  localparam int unsigned PER_LIM     = PER_MAX + 1;
  localparam int unsigned PER_W       = $clog2(PER_LIM + 1);
  localparam int unsigned SGL_MIN_PER = REF_HZ / SGL_MAX_HZ;
  localparam int unsigned DBL_MIN_PER = REF_HZ / DBL_MAX_HZ;

  logic rst_ref_n, rst_mclk_n;
  logic lrck_m, lrck_r;
  logic [MCNT_W-1:0] mcnt_hold;
  logic mcnt_tog, tog_r, tog_q, evt;
  logic [PER_W-1:0] period;
  logic stall;
  band_e band;
  logic [RCODE_W-1:0] code;
  logic ok;

  cmd_sync #(.STAGES(SYNC_STAGES)) u_rst_ref  (.clk(ref_clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_ref_n));
  cmd_sync #(.STAGES(SYNC_STAGES)) u_rst_mclk (.clk(mclk),    .rst_n(rst_n), .d_i(1'b1), .q_o(rst_mclk_n));
  cmd_sync #(.STAGES(SYNC_STAGES)) u_lrck_m   (.clk(mclk),    .rst_n(rst_mclk_n), .d_i(lrck), .q_o(lrck_m));
  cmd_sync #(.STAGES(SYNC_STAGES)) u_lrck_r   (.clk(ref_clk), .rst_n(rst_ref_n),  .d_i(lrck), .q_o(lrck_r));

  cmd_mclk_count #(.MCNT_W(MCNT_W)) u_mcnt (
    .mclk(mclk), .rst_n(rst_mclk_n), .lrck_s(lrck_m), .hold_o(mcnt_hold), .tog_o(mcnt_tog)
  );

  // toggle event into the reference domain; the count register is held for a full frame
  cmd_sync #(.STAGES(SYNC_STAGES)) u_tog_r (.clk(ref_clk), .rst_n(rst_ref_n), .d_i(mcnt_tog), .q_o(tog_r));

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) tog_q <= 1'b0;
    else            tog_q <= tog_r;
  end

  assign evt = tog_r ^ tog_q;

  cmd_rate_meter #(.PER_W(PER_W), .PER_LIM(PER_LIM)) u_rate (
    .clk(ref_clk), .rst_n(rst_ref_n), .lrck_s(lrck_r), .period_o(period), .stall_o(stall)
  );

  cmd_classify #(
    .PER_W(PER_W), .MCNT_W(MCNT_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
    .SGL_MIN_PER(SGL_MIN_PER), .DBL_MIN_PER(DBL_MIN_PER), .TOL(TOL),
    .SGL_AUTO(SGL_AUTO), .DBL_AUTO(DBL_AUTO), .QUAD_AUTO(QUAD_AUTO)
  ) u_cls (
    .period_i(period), .mcount_i(mcnt_hold), .band_o(band), .code_o(code), .ok_o(ok)
  );

  cmd_lock_track #(.LOCK_RUNS(LOCK_RUNS)) u_lock (
    .clk(ref_clk), .rst_n(rst_ref_n), .evt_i(evt), .stall_i(stall),
    .band_i(band), .code_i(code), .ok_i(ok),
    .mode_o(mode_o), .ratio_o(ratio_o), .locked_o(locked_o), .unsup_o(unsupported_o)
  );

  // R4: an accepted ratio always comes with a resolved band
  a_r4_ok_needs_band: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (evt && ok) |-> band != BAND_NONE);
endmodule

// File: tb/clkmode_detect_bench.sv
`timescale 1ps/1ps
module clkmode_detect_bench;
  logic ref_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic mclk    = 1'b0;
  logic lrck    = 1'b0;
  logic [1:0] mode_o;
  logic [3:0] ratio_o;
  logic locked_o, unsupported_o;

  int mclk_half = 4000;
  int hi_len = 128, lo_len = 128, lr_cnt = 0;
  bit lr_run = 1'b0;
  int edges = 0, edge_base = 0;
  int n_checks = 0, n_fail = 0;
  int mon_checks = 0, mon_fails = 0;
  bit mon_en = 1'b0;
  int scen_id = 0, seen_id = 0;
  int rise_rel = -1;
  bit saw_low = 1'b0, prev_lock = 1'b0;

  clkmode_detect #(.REF_HZ(12_500_000)) u_clkmode_detect (
    .ref_clk(ref_clk), .rst_n(rst_n), .mclk(mclk), .lrck(lrck),
    .mode_o(mode_o), .ratio_o(ratio_o), .locked_o(locked_o), .unsupported_o(unsupported_o)
  );

  always #4000 ref_clk = ~ref_clk;
  always begin #(mclk_half); mclk = ~mclk; end

  always @(negedge mclk) begin
    if (lr_run) begin
      if (lr_cnt + 1 >= (lrck ? hi_len : lo_len)) begin lrck <= ~lrck; lr_cnt <= 0; end
      else lr_cnt <= lr_cnt + 1;
    end
  end

  always @(posedge lrck) edges <= edges + 1;

  // per-clock monitor: output invariants and lock timing after each switch
  always @(negedge ref_clk) begin
    if (mon_en) begin
      if (scen_id != seen_id) begin seen_id = scen_id; rise_rel = -1; saw_low = 1'b0; end
      if (!locked_o) saw_low = 1'b1;
      if (locked_o && !prev_lock && rise_rel < 0) rise_rel = edges - edge_base;
      prev_lock = locked_o;
      mon_checks++;
      if (locked_o && (unsupported_o || mode_o == 2'd0 || ratio_o == 4'd0)) begin
        mon_fails++;
        $display("FAIL R7 locked invariant actual unsup=%0d mode=%0d ratio=%0d expected unsup=0 mode!=0 ratio!=0",
                 unsupported_o, mode_o, ratio_o);
      end
      if (unsupported_o && (ratio_o != 4'd0 || locked_o)) begin
        mon_fails++;
        $display("FAIL R7 unsupported invariant actual ratio=%0d locked=%0d expected ratio=0 locked=0",
                 ratio_o, locked_o);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int band_of(int fs);
    if (fs < 30000 || fs > 220000) return 0;
    if (fs <= 50000) return 1;
    if (fs <= 100000) return 2;
    return 3;
  endfunction

  function automatic int code_of(int r);
    case (r)
      64: return 1;   96: return 2;   128: return 3;  192: return 4;  256: return 5;
      384: return 6;  512: return 7;  768: return 8;  1024: return 9; 1152: return 10;
      default: return 0;
    endcase
  endfunction

  // R4 band sets, R5 tolerance, R6 masked 1152x in single speed
  function automatic int exp_code(int band, int r, int delta);
    int c;
    c = code_of(r);
    if (band == 0 || delta > 2 || delta < -2) return 0;
    if (band == 1 && !(c >= 5 && c <= 9)) return 0;
    if (band == 2 && !(c >= 3 && c <= 7)) return 0;
    if (band == 3 && !(c >= 1 && c <= 5)) return 0;
    return c;
  endfunction

  task automatic scen(input string req, input int fs, input int r, input int delta, input bit chk_lock);
    int b, c;
    b = band_of(fs);
    c = exp_code(b, r, delta);
    if (lr_run) @(posedge lrck);
    mclk_half = int'(1.0e11 / (real'(fs) * real'(r) * 2.0));
    hi_len    = r / 2;
    lo_len    = r / 2 + delta;
    edge_base = edges;
    scen_id++;
    lr_run    = 1'b1;
    while (edges - edge_base < 10) @(negedge ref_clk);
    repeat (20) @(negedge ref_clk);
    chk(req, $sformatf("mode fs=%0d r=%0d d=%0d", fs, r, delta), mode_o, b);
    chk(req, $sformatf("ratio fs=%0d r=%0d d=%0d", fs, r, delta), ratio_o, c);
    chk(req, $sformatf("locked fs=%0d r=%0d d=%0d", fs, r, delta), locked_o, c != 0);
    chk(req, $sformatf("unsupported fs=%0d r=%0d d=%0d", fs, r, delta), unsupported_o, c == 0);
    if (chk_lock) begin
      chk("R9", "lock dropped after switch", saw_low, 1);
      chk("R8", "frames before lock >= 4", (rise_rel >= 4) ? 1 : 0, 1);
    end
  endtask

  initial begin
    repeat (5) @(negedge ref_clk);
    // R1 reset values
    chk("R1", "mode in reset", mode_o, 0);
    chk("R1", "locked in reset", locked_o, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge ref_clk);
    chk("R1", "mode after reset", mode_o, 0);
    chk("R1", "ratio after reset", ratio_o, 0);
    chk("R1", "locked after reset", locked_o, 0);
    chk("R1", "unsupported after reset", unsupported_o, 0);
    mon_en = 1'b1;

    scen("R2 R3", 48000, 256, 0, 1'b1);
    scen("R3 R9", 44100, 384, 0, 1'b1);
    scen("R3", 32000, 1024, 0, 1'b1);
    scen("R2 R4", 96000, 256, 0, 1'b1);
    scen("R4", 88200, 128, 0, 1'b1);
    scen("R4", 64000, 192, 0, 1'b1);
    scen("R2 R4", 192000, 256, 0, 1'b1);
    scen("R4", 176400, 64, 0, 1'b1);
    scen("R4 R7", 192000, 512, 0, 1'b0);
    scen("R6", 32000, 1152, 0, 1'b0);
    scen("R5", 48000, 256, 2, 1'b1);
    scen("R5", 48000, 256, -2, 1'b0);
    scen("R5", 48000, 256, 3, 1'b0);
    scen("R2", 20000, 256, 0, 1'b0);

    // R10: stop the frame clock
    @(posedge lrck);
    lr_run = 1'b0;
    repeat (600) @(negedge ref_clk);
    chk("R10", "mode on stall", mode_o, 0);
    chk("R10", "ratio on stall", ratio_o, 0);
    chk("R10", "locked on stall", locked_o, 0);
    chk("R10", "unsupported on stall", unsupported_o, 1);

    scen("R10", 48000, 512, 0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks + mon_checks, n_fail + mon_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge ref_clk);
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks + mon_checks + 1, n_fail + mon_fails + 1);
    $finish;
  end
endmodule